// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the timer slice of a per-core interrupt controller. Software programs three registers through a plain 32-bit register port with one select line per register: a divide configuration, an initial count and a timer entry holding the vector, a mask bit and a mode bit. A fourth select reads back the live count. A prescaler turns the core clock into count ticks at a power-of-two rate picked by the divide code. Writing a nonzero initial count starts a countdown. When the count runs out, the block emits a one-cycle interrupt request carrying the programmed vector, unless the entry is masked.

In one-shot mode the timer stops at zero. In periodic mode it reloads the initial count and keeps running. Writing a zero initial count stops the timer at once. The live-count read reports the number of whole ticks still needed, rounded up, so a count that has only partly elapsed still reads as one.

Top module: `lic_timer`

## Requirements
- R1: After reset, the divide, initial-count and live-count reads return 0, the timer entry reads 0x00010000 (masked), and irqValid is low.
- R2: The divide exponent is e = {cfg[3], cfg[1:0]}. The tick period is D = 2^((e+1) mod 8) core cycles, so cfg 0x0 gives D=2 and cfg 0xB gives D=1. A divide read returns only bits 3, 1 and 0 of the last write.
- R3: In one-shot mode (entry bit 17 = 0), after a write of nonzero N to the initial count on clock edge E, irqValid is high only in the cycle after edge E+N*D. After that the timer is idle.
- R4: The live-count read returns the remaining core cycles divided by D, rounded up, which is N - floor(k/D) after edge E+k for k < N*D. It returns 0 whenever the timer is not running.
- R5: Writing a nonzero initial count while the timer runs restarts the countdown from the new value with the current divisor. No interrupt is raised for the abandoned countdown.
- R6: Writing 0 to the initial count stops the timer. The live count reads 0 and no interrupt follows.
- R7: Timer entry layout: vector in bits 7:0, mask in bit 16, periodic mode in bit 17. Bits 12 and 14 are read-only and read 0, so writing 0xFFFFFFFF reads back 0xFFFFAFFF. All other bits read back as written.
- R8: In periodic mode (entry bit 17 = 1), the counter reloads N on reaching zero. irqValid pulses after every edge E+m*N*D, for m >= 1.
- R9: With the mask bit set, reaching zero raises no request. The counter still stops or reloads as its mode dictates.
- R10: A divide write during a countdown takes effect from the next count tick: the tick already in progress completes at the old rate.
- R11: irqVector carries the entry's bits 7:0 in every cycle where irqValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rstN | input | 1 | asynchronous active-low reset |
| selDiv | input | 1 | selects the divide configuration register |
| selInit | input | 1 | selects the initial-count register |
| selCur | input | 1 | selects the live-count read |
| selLvt | input | 1 | selects the timer entry register |
| wrEn | input | 1 | write strobe for the selected register |
| wrData | input | 32 | write data |
| rdData | output | 32 | read data of the selected register (combinational) |
| irqValid | output | 1 | one-cycle interrupt request |
| irqVector | output | 8 | vector that accompanies irqValid |

## Verification
The bench sweeps all eight divide codes against several short counts. At every cycle it compares the live count with the rounded-up quotient and checks the exact cycle of the request. A divider that decoded bit 2, or failed to wrap the exponent, would land the request at a wrong multiple of the count. A read that truncated instead of rounding up would report one less on every partial tick. Directed cases then cover the following:
- a periodic timer that must reload instead of stopping;
- a masked timer that must stay silent while it still reloads;
- a restart and a zero write issued mid-count, where a stale countdown would fire late;
- a divide change mid-tick, where applying the new rate at once would shift the request by several cycles.

// File: rtl/lic_timer_pkg.sv
package lic_timer_pkg;

  // register and count width
  localparam int DATA_W = 32;
  // width of the divide exponent
  localparam int EXP_W = 3;
  // largest prescale value is 2^(2^EXP_W - 1) - 1
  localparam int PRE_W = (1 << EXP_W) - 1;
  localparam int VEC_W = 8;

  // timer entry fields
  localparam int LVT_STATUS_BIT = 12;
  localparam int LVT_RSVD_BIT = 14;
  localparam int LVT_MASK_BIT = 16;
  localparam int LVT_PERIODIC_BIT = 17;
  localparam logic [DATA_W-1:0] LVT_RO_MASK =
      (DATA_W'(1) << LVT_STATUS_BIT) | (DATA_W'(1) << LVT_RSVD_BIT);
  localparam logic [DATA_W-1:0] LVT_RESET =
      DATA_W'(1) << LVT_MASK_BIT;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;    // start from loadVal
    logic halt;    // stop on a zero write
    logic tick;    // count down by one
    logic reload;  // periodic restart at zero
    logic finish;  // one-shot end at zero
    logic fire;    // raise the request
  } ltStrobes_t;

endpackage

// File: rtl/lic_timer_divdec.sv
module lic_timer_divdec
  import lic_timer_pkg::*;
(
  input  logic [EXP_W-1:0] divCode,
  output logic [PRE_W-1:0] preLoad
);

  // exponent + 1 wraps modulo 2^EXP_W, so the all-ones code divides by one
  logic [EXP_W-1:0] shiftAmt;
  assign shiftAmt = divCode + 1'b1;

  // thermometer code: prescale reload = 2^shiftAmt - 1
  generate
    for (genvar i = 0; i < PRE_W; i++) begin : g_therm
      assign preLoad[i] = (int'(shiftAmt) > i);
    end
  endgenerate

endmodule

// File: rtl/lic_timer_ctrl.sv
module lic_timer_ctrl
  import lic_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              selDiv,
  input  logic              selInit,
  input  logic              selCur,
  input  logic              selLvt,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              running,
  input  logic              preZero,
  input  logic              cntOne,
  input  logic [DATA_W-1:0] curCnt,
  output ltStrobes_t        strb,
  output logic [DATA_W-1:0] loadVal,
  output logic [PRE_W-1:0]  preLoad,
  output logic [VEC_W-1:0]  vecOut
);

  logic [EXP_W-1:0]  divReg;   // {cfg[3], cfg[1:0]}
  logic [DATA_W-1:0] initReg;
  logic [DATA_W-1:0] lvtReg;
  logic              wrDiv;
  logic              wrInit;
  logic              wrLvt;
  logic [DATA_W-1:0] divRead;

  assign wrDiv  = wrEn && selDiv;
  assign wrInit = wrEn && selInit;
  assign wrLvt  = wrEn && selLvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= '0;
      initReg <= '0;
      lvtReg  <= LVT_RESET;
    end else begin
      if (wrDiv) begin
        divReg <= {wrData[3], wrData[1:0]};
      end
      if (wrInit) begin
        initReg <= wrData;
      end
      if (wrLvt) begin
        lvtReg <= (wrData & ~LVT_RO_MASK) | (lvtReg & LVT_RO_MASK);
      end
    end
  end

  lic_timer_divdec u_divdec (
    .divCode (divReg),
    .preLoad (preLoad)
  );

  assign divRead = DATA_W'({divReg[2], 1'b0, divReg[1:0]});
  assign vecOut  = lvtReg[VEC_W-1:0];

  always_comb begin
    rdData = ({DATA_W{selDiv}}  & divRead)
           | ({DATA_W{selInit}} & initReg)
           | ({DATA_W{selCur}}  & curCnt)
           | ({DATA_W{selLvt}}  & lvtReg);
  end

  // strobe generation: an initial-count write takes priority over counting
  always_comb begin
    strb    = '0;
    loadVal = initReg;
    if (wrInit) begin
      loadVal = wrData;
      if (wrData != '0) begin
        strb.load = 1'b1;
      end else begin
        strb.halt = 1'b1;
      end
    end else if (running && preZero) begin
      if (cntOne) begin
        strb.fire = !lvtReg[LVT_MASK_BIT];
        if (lvtReg[LVT_PERIODIC_BIT]) begin
          strb.reload = 1'b1;
        end else begin
          strb.finish = 1'b1;
        end
      end else begin
        strb.tick = 1'b1;
      end
    end
  end

  // register port: at most one select at a time
  reg_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selDiv, selInit, selCur, selLvt}));

  // R7
  lvt_ro_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(lvtReg[LVT_STATUS_BIT]) && $stable(lvtReg[LVT_RSVD_BIT]));

  // R2
  div_read_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    selDiv |-> (rdData[DATA_W-1:4] == '0 && rdData[2] == 1'b0));

  // R9
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    lvtReg[LVT_MASK_BIT] |-> !strb.fire);

  // R5
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrInit |-> !(strb.tick || strb.reload || strb.finish || strb.fire));

endmodule

// File: rtl/lic_timer_dpath.sv
module lic_timer_dpath
  import lic_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ltStrobes_t        strb,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [PRE_W-1:0]  preLoad,
  input  logic [VEC_W-1:0]  vecIn,
  output logic              running,
  output logic              preZero,
  output logic              cntOne,
  output logic [DATA_W-1:0] curCnt,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);

  logic [PRE_W-1:0]  pre;
  logic [DATA_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre       <= '0;
      cnt       <= '0;
      running   <= 1'b0;
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid <= strb.fire;
      if (strb.fire) begin
        irqVector <= vecIn;
      end
      if (strb.load) begin
        cnt     <= loadVal;
        pre     <= preLoad;
        running <= 1'b1;
      end else if (strb.halt || strb.finish) begin
        cnt     <= '0;
        pre     <= '0;
        running <= 1'b0;
      end else if (strb.reload) begin
        cnt <= loadVal;
        pre <= preLoad;
      end else if (strb.tick) begin
        cnt <= cnt - 1'b1;
        pre <= preLoad;
      end else if (running) begin
        pre <= pre - 1'b1;
      end
    end
  end

  // cnt is the rounded-up count of remaining ticks; pre holds the partial tick
  assign preZero = (pre == '0);
  assign cntOne  = (cnt == DATA_W'(1));
  assign curCnt  = cnt;

  // R4
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (cnt == '0));

  // R3
  irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> $past(running));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$past(strb.load) && !$past(strb.reload))
      |-> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  // R6
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.halt |=> (!running && !irqValid));

endmodule

// File: rtl/lic_timer.sv
module lic_timer
  import lic_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              selDiv,
  input  logic              selInit,
  input  logic              selCur,
  input  logic              selLvt,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);

  ltStrobes_t        strb;
  logic [DATA_W-1:0] loadVal;
  logic [PRE_W-1:0]  preLoad;
  logic [VEC_W-1:0]  vecSel;
  logic              running;
  logic              preZero;
  logic              cntOne;
  logic [DATA_W-1:0] curCnt;

  lic_timer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selDiv  (selDiv),
    .selInit (selInit),
    .selCur  (selCur),
    .selLvt  (selLvt),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .running (running),
    .preZero (preZero),
    .cntOne  (cntOne),
    .curCnt  (curCnt),
    .strb    (strb),
    .loadVal (loadVal),
    .preLoad (preLoad),
    .vecOut  (vecSel)
  );

  lic_timer_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadVal   (loadVal),
    .preLoad   (preLoad),
    .vecIn     (vecSel),
    .running   (running),
    .preZero   (preZero),
    .cntOne    (cntOne),
    .curCnt    (curCnt),
    .irqValid  (irqValid),
    .irqVector (irqVector)
  );

endmodule

// File: tb/lic_timer_tb_top.sv
module lic_timer_tb_top;

  localparam int RDIV = 0;
  localparam int RINIT = 1;
  localparam int RCUR = 2;
  localparam int RLVT = 3;
  localparam int PER = 32'h0002_0000;
  localparam int MSK = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selDiv = 1'b0, selInit = 1'b0, selCur = 1'b0, selLvt = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqValid;
  logic [7:0]  irqVector;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lic_timer dut_i (
    .clk(clk), .rstN(rstN), .selDiv(selDiv), .selInit(selInit),
    .selCur(selCur), .selLvt(selLvt), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqValid(irqValid), .irqVector(irqVector)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setSel(input int r, input logic v);
    selDiv  = (r == RDIV)  ? v : 1'b0;
    selInit = (r == RINIT) ? v : 1'b0;
    selCur  = (r == RCUR)  ? v : 1'b0;
    selLvt  = (r == RLVT)  ? v : 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wrReg(input int r, input logic [31:0] d);
    setSel(r, 1'b1);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    setSel(r, 1'b0);
  endtask

  task automatic rdReg(input int r, output logic [31:0] d);
    setSel(r, 1'b1);
    #1;
    d = rdData;
    setSel(r, 1'b0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] divCfg(input int c);
    return {28'd0, c[2], 1'b0, c[1:0]};
  endfunction

  function automatic int divOf(input int c);
    return 1 << ((c + 1) % 8);
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(RDIV, v);  chk(v == 0, "R1", "div reset", v, 0);
    rdReg(RINIT, v); chk(v == 0, "R1", "init reset", v, 0);
    rdReg(RCUR, v);  chk(v == 0, "R1", "cur reset", v, 0);
    rdReg(RLVT, v);  chk(v == 32'h0001_0000, "R1", "lvt reset", v, 32'h0001_0000);
    chk(irqValid == 0, "R1", "irq reset", irqValid, 0);

    // R2 divide readback
    wrReg(RDIV, 32'hFFFF_FFFF);
    rdReg(RDIV, v); chk(v == 32'hB, "R2", "div readback", v, 32'hB);

    // R7 timer entry read-only bits
    wrReg(RLVT, 32'hFFFF_FFFF);
    rdReg(RLVT, v); chk(v == 32'hFFFF_AFFF, "R7", "lvt ones", v, 32'hFFFF_AFFF);
    wrReg(RLVT, 32'h0);
    rdReg(RLVT, v); chk(v == 32'h0, "R7", "lvt zero", v, 0);

    // R2 R3 R4 R11 one-shot sweep over every divide code
    for (int c = 0; c < 8; c++) begin
      for (int ni = 0; ni < 4; ni++) begin
        int n;
        int d;
        logic [7:0] vec;
        n = (ni == 3) ? 5 : ni + 1;
        d = divOf(c);
        vec = 8'(8'h20 + c * 4 + ni);
        wrReg(RLVT, {24'd0, vec});
        wrReg(RDIV, divCfg(c));
        wrReg(RINIT, n);
        for (int k = 0; k <= n * d + 1; k++) begin
          int e;
          if (k > 0) step();
          e = (k < n * d) ? n - k / d : 0;
          rdReg(RCUR, v);
          chk(v == e, "R4", "cur rounded up", v, e);
          chk(irqValid == (k == n * d), "R3", "one-shot irq timing", irqValid, (k == n * d));
          if (k == n * d) chk(irqVector == vec, "R11", "vector", irqVector, vec);
        end
      end
    end

    // R8 periodic: D=4, N=3, period 12
    wrReg(RLVT, PER | 32'h77);
    wrReg(RDIV, divCfg(1));
    wrReg(RINIT, 3);
    for (int k = 0; k <= 38; k++) begin
      int e;
      if (k > 0) step();
      e = 3 - (k % 12) / 4;
      rdReg(RCUR, v);
      chk(v == e, "R8", "periodic count", v, e);
      chk(irqValid == (k > 0 && k % 12 == 0), "R8", "periodic irq", irqValid, (k > 0 && k % 12 == 0));
      if (irqValid) chk(irqVector == 8'h77, "R11", "periodic vector", irqVector, 8'h77);
    end
    wrReg(RINIT, 0);

    // R9 masked periodic: D=2, N=2, still reloads, never requests
    wrReg(RLVT, PER | MSK | 32'h55);
    wrReg(RDIV, divCfg(0));
    wrReg(RINIT, 2);
    for (int k = 0; k <= 12; k++) begin
      int e;
      if (k > 0) step();
      e = 2 - (k % 4) / 2;
      rdReg(RCUR, v);
      chk(v == e, "R9", "masked reload count", v, e);
      chk(irqValid == 0, "R9", "masked irq", irqValid, 0);
    end
    wrReg(RINIT, 0);

    // R6 zero write stops the timer
    wrReg(RLVT, 32'h41);
    wrReg(RDIV, divCfg(7));
    wrReg(RINIT, 10);
    repeat (3) step();
    wrReg(RINIT, 0);
    for (int k = 0; k <= 20; k++) begin
      if (k > 0) step();
      rdReg(RCUR, v);
      chk(v == 0, "R6", "stopped count", v, 0);
      chk(irqValid == 0, "R6", "stopped irq", irqValid, 0);
    end

    // R5 restart while running: D=2
    wrReg(RDIV, divCfg(0));
    wrReg(RINIT, 10);
    repeat (5) step();
    wrReg(RINIT, 3);
    for (int k = 0; k <= 8; k++) begin
      int e;
      if (k > 0) step();
      e = (k < 6) ? 3 - k / 2 : 0;
      rdReg(RCUR, v);
      chk(v == e, "R5", "restart count", v, e);
      chk(irqValid == (k == 6), "R5", "restart irq", irqValid, (k == 6));
    end

    // R10 divide change mid-tick: 2 cycles at old D=2, then 3 ticks at D=8
    wrReg(RLVT, 32'h31);
    wrReg(RDIV, divCfg(0));
    wrReg(RINIT, 4);
    wrReg(RDIV, divCfg(2));
    for (int k = 1; k <= 28; k++) begin
      int e;
      if (k > 1) step();
      e = (k < 2) ? 4 : ((k < 26) ? 3 - (k - 2) / 8 : 0);
      rdReg(RCUR, v);
      chk(v == e, "R10", "divide change count", v, e);
      chk(irqValid == (k == 26), "R10", "divide change irq", irqValid, (k == 26));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule